// File: doc/BRIEF.md
# Bidirectional General-Purpose Port

This block is an eight-bit general-purpose pin port, controlled through a small register bus. Each pin can act as an input or an output. Outputs come from a data latch, and a per-bit direction register decides which pins drive. A read of the port register returns the levels seen on the pins after synchronization, not the latch contents. The bit-set and bit-clear accesses follow the same rule: they take the pin view, change one bit and write the whole word back into the latch.

A per-bit analog-select register makes pins read as zero on every port read. Only the bits marked analog-capable by a parameter can be set in it. Per-bit peripheral-select inputs let another block take over a pin's data and output enable. One bit is an open-drain output. A single active-low control bit enables weak pull-ups, and the pull-up on any pin that is currently driving is removed automatically. The pad side is split into separate out, output-enable, pull-up-enable and in vectors, so the block contains no tristate logic.

The bus is a single-cycle strobe with no wait states. A write takes effect on the clock edge where `bus_req` and `bus_we` are both high. `bus_rdata` is combinational from `bus_addr` at all times.

Top module: `gpio_port`

## Requirements
- R1: After reset, all pins are inputs. Direction reads 0xFF, the latch is 0, `pad_oe` and `pad_pu` are 0, the pull-up control reads 1 (pull-ups off), and the analog register reads the analog-capable mask (0x0F by default).
- R2: A pin with direction bit 0 and no peripheral select drives its latch bit: `pad_oe` is 1 and `pad_out` equals the latch. Direction bit 1 clears `pad_oe`.
- R3: A read at address 0 returns the pin levels two clock edges after they change on `pad_in`, whatever the direction bits are.
- R4: A write at address 0 loads `bus_wdata` into the output latch. A write at address 1 loads the direction register.
- R5: A write at address 2 (set) or address 3 (clear) takes the current port read value, sets or clears the bit selected by `bus_wdata[2:0]`, and stores the result in the latch. An input pin's latch bit therefore becomes its pin level.
- R6: A bit set in the analog register (address 5) reads as 0 at address 0 and is written back as 0 by set and clear accesses. The pin can still drive its latch value as an output.
- R7: When `per_sel[i]` is 1, pin i takes its data from `per_dout[i]` and its output enable from `per_oe[i]`. When `per_sel[i]` is 0, `per_oe[i]` and `per_dout[i]` have no effect.
- R8: Bit 4 is open-drain. Its `pad_out` is always 0, and `pad_oe[4]` is 1 only when the selected data value is 0.
- R9: Pull-up control bit 0 at address 4 is active low. `pad_pu[i]` is 1 exactly when that bit is 0 and pin i is not configured as an output.
- R10: Bits of the analog register outside the analog-capable mask cannot be set. A write of 0xFF reads back as the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access strobe |
| bus_we | input | 1 | 1 for a write access |
| bus_addr | input | 3 | Register select: 0 port, 1 direction, 2 set, 3 clear, 4 pull-up control, 5 analog |
| bus_wdata | input | 8 | Write data (bits 2:0 give the bit index for set and clear) |
| bus_rdata | output | 8 | Read data for `bus_addr` (0 for addresses 2, 3, 6 and 7) |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Data to the pad drivers |
| pad_oe | output | 8 | Per-pin driver enable |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| per_sel | input | 8 | Per-pin peripheral takeover |
| per_dout | input | 8 | Peripheral output data |
| per_oe | input | 8 | Peripheral output enable, used only while selected |

## Verification
The assertions check four things on every cycle:
- a driving pin never has its pull-up on, and unselected pins follow the direction register;
- the open-drain bit only drives while its value is low;
- analog pins read zero, and the analog register never holds bits outside the mask;
- each latch update matches the write, set or clear that caused it.

Three behaviours can only be shown by the bench's scenarios:
- the two-edge synchronizer latency;
- the read-modify-write hazard, where an input pin's level overwrites its latch bit and an analog pin is written back as zero;
- the exact pad vectors seen under peripheral takeover.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [2:0] {
        REG_PORT  = 3'd0,
        REG_DIR   = 3'd1,
        REG_SET   = 3'd2,
        REG_CLR   = 3'd3,
        REG_PUCTL = 3'd4,
        REG_ANA   = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_in;
            d_sync <= stage1;
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int         W       = 8,
    parameter logic [W-1:0] ANA_CAP = 8'h0F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_req,
    input  logic         bus_we,
    input  logic [2:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] lat_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] ana_q,
    output logic         pu_n_q,
    output logic [W-1:0] pin_view,
    output logic [W-1:0] bus_rdata
);

    localparam int IDX_W = $clog2(W);

    reg_addr_e     addr;
    logic          wr;
    logic [IDX_W-1:0] bit_idx;
    logic [W-1:0]  bit_mask;
    logic [W-1:0]  lat_d;

    assign addr     = reg_addr_e'(bus_addr);
    assign wr       = bus_req && bus_we;
    assign bit_idx  = bus_wdata[IDX_W-1:0];
    assign bit_mask = {{(W-1){1'b0}}, 1'b1} << bit_idx;
    assign pin_view = pin_sync & ~ana_q;

    always_comb begin
        lat_d = lat_q;
        if (wr) begin
            unique case (addr)
                REG_PORT: lat_d = bus_wdata;
                REG_SET:  lat_d = pin_view | bit_mask;
                REG_CLR:  lat_d = pin_view & ~bit_mask;
                default:  lat_d = lat_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= '0;
            dir_q  <= '1;
            ana_q  <= ANA_CAP;
            pu_n_q <= 1'b1;
        end else begin
            lat_q <= lat_d;
            if (wr && addr == REG_DIR)   dir_q  <= bus_wdata;
            if (wr && addr == REG_ANA)   ana_q  <= bus_wdata & ANA_CAP;
            if (wr && addr == REG_PUCTL) pu_n_q <= bus_wdata[0];
        end
    end

    always_comb begin
        unique case (addr)
            REG_PORT:  bus_rdata = pin_view;
            REG_DIR:   bus_rdata = dir_q;
            REG_PUCTL: bus_rdata = {{(W-1){1'b0}}, pu_n_q};
            REG_ANA:   bus_rdata = ana_q;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad #(
    parameter int W      = 8,
    parameter int OD_BIT = 4
) (
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] dir_q,
    input  logic         pu_n_q,
    input  logic [W-1:0] per_sel,
    input  logic [W-1:0] per_dout,
    input  logic [W-1:0] per_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic data_sel;
        logic drive_sel;

        assign data_sel  = per_sel[i] ? per_dout[i] : lat_q[i];
        assign drive_sel = per_sel[i] ? per_oe[i]   : ~dir_q[i];
        assign pad_pu[i] = ~pu_n_q & ~drive_sel;

        if (i == OD_BIT) begin : g_od
            assign pad_out[i] = 1'b0;
            assign pad_oe[i]  = drive_sel & ~data_sel;
        end else begin : g_pp
            assign pad_out[i] = data_sel;
            assign pad_oe[i]  = drive_sel;
        end
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int           W       = 8,
    parameter int           OD_BIT  = 4,
    parameter logic [W-1:0] ANA_CAP = 8'h0F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_req,
    input  logic         bus_we,
    input  logic [2:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    input  logic [W-1:0] per_sel,
    input  logic [W-1:0] per_dout,
    input  logic [W-1:0] per_oe
);

    logic [W-1:0] pin_sync;
    logic [W-1:0] pin_view;
    logic [W-1:0] lat_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] ana_q;
    logic         pu_n_q;

    gpio_port_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (pad_in),
        .d_sync (pin_sync)
    );

    gpio_port_regs #(.W(W), .ANA_CAP(ANA_CAP)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .lat_q     (lat_q),
        .dir_q     (dir_q),
        .ana_q     (ana_q),
        .pu_n_q    (pu_n_q),
        .pin_view  (pin_view),
        .bus_rdata (bus_rdata)
    );

    gpio_port_pad #(.W(W), .OD_BIT(OD_BIT)) u_pad (
        .lat_q    (lat_q),
        .dir_q    (dir_q),
        .pu_n_q   (pu_n_q),
        .per_sel  (per_sel),
        .per_dout (per_dout),
        .per_oe   (per_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .pad_pu   (pad_pu)
    );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int           W       = 8,
    parameter int           OD_BIT  = 4,
    parameter logic [W-1:0] ANA_CAP = 8'h0F
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_req,
    input logic         bus_we,
    input logic [2:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] bus_rdata,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] per_sel,
    input logic [W-1:0] lat_q,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] ana_q,
    input logic [W-1:0] pin_view
);

    localparam logic [W-1:0] OD_MASK = {{(W-1){1'b0}}, 1'b1} << OD_BIT;
    localparam int IDX_W = $clog2(W);

    // R9: a driving pin never has its pull-up on
    a_r9_no_pullup_on_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R2 / R7: pins not taken over by a peripheral follow the direction register
    a_r7_unselected_follow_dir: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ ~dir_q) & ~per_sel & ~OD_MASK) == '0);

    // R8: the open-drain pin only drives while its latch bit is low
    a_r8_od_drives_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe[OD_BIT] && !per_sel[OD_BIT]) |-> !lat_q[OD_BIT]);

    // R6: analog pins read zero on a port read
    a_r6_analog_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd0) |-> ((bus_rdata & ana_q) == '0));

    // R10: the analog register never holds a bit outside the capable mask
    a_r10_ana_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (ana_q & ~ANA_CAP) == '0);

    // R4: a port write loads the latch
    a_r4_port_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == 3'd0) |=> (lat_q == $past(bus_wdata)));

    // R5: a set access stores the pin view with the chosen bit set
    a_r5_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == 3'd2) |=>
        (lat_q == ($past(pin_view) | ({{(W-1){1'b0}}, 1'b1} << $past(bus_wdata[IDX_W-1:0])))));

    // R5: a clear access stores the pin view with the chosen bit cleared
    a_r5_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == 3'd3) |=>
        (lat_q == ($past(pin_view) & ~({{(W-1){1'b0}}, 1'b1} << $past(bus_wdata[IDX_W-1:0])))));

endmodule

bind gpio_port gpio_port_chk #(.W(W), .OD_BIT(OD_BIT), .ANA_CAP(ANA_CAP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .per_sel   (per_sel),
    .lat_q     (lat_q),
    .dir_q     (dir_q),
    .ana_q     (ana_q),
    .pin_view  (pin_view)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] pad_pu;
    logic [7:0] per_sel = 8'h00;
    logic [7:0] per_dout = 8'h00;
    logic [7:0] per_oe = 8'h00;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef enum int {K_RD, K_OUT, K_OE, K_PU} kind_e;
    typedef struct {
        kind_e      kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    gpio_port u_gpio_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .per_sel   (per_sel),
        .per_dout  (per_dout),
        .per_oe    (per_oe)
    );

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            unique case (it.kind)
                K_RD:  act = bus_rdata;
                K_OUT: act = pad_out;
                K_OE:  act = pad_oe;
                default: act = pad_pu;
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    // all tasks start and end at posedge + 1ns
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_req = 1'b1;
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic expect_item(input kind_e k, input logic [7:0] e, input string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string r);
        bus_addr = a;
        expect_item(K_RD, e, r);
        @(posedge clk); #1;
    endtask

    task automatic pad_chk(input logic [7:0] eo, input logic [7:0] ee, input logic [7:0] ep, input string r);
        expect_item(K_OUT, eo, r);
        expect_item(K_OE, ee, r);
        expect_item(K_PU, ep, r);
        @(posedge clk); #1;
    endtask

    task automatic set_pins(input logic [7:0] v);
        pad_in = v;
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        rd_chk(3'd1, 8'hFF, "R1 dir");
        rd_chk(3'd5, 8'h0F, "R1 ana");
        rd_chk(3'd4, 8'h01, "R1 puctl");
        pad_chk(8'h00, 8'h00, 8'h00, "R1 pads");

        // R10: analog writes limited to the capable mask
        wr(3'd5, 8'hFF);
        rd_chk(3'd5, 8'h0F, "R10");

        // R3 / R6: pins read through sync, analog bits read zero
        set_pins(8'h3C);
        rd_chk(3'd0, 8'h30, "R6 analog read");
        wr(3'd5, 8'h00);
        rd_chk(3'd0, 8'h3C, "R3 input read");

        // R4 / R2 / R8: outputs drive the latch, bit 4 open-drain
        wr(3'd1, 8'h00);
        rd_chk(3'd1, 8'h00, "R4 dir write");
        wr(3'd0, 8'hA5);
        pad_chk(8'hA5, 8'hFF, 8'h00, "R2 drive A5");
        rd_chk(3'd0, 8'h3C, "R3 read pins not latch");
        wr(3'd0, 8'hFF);
        pad_chk(8'hEF, 8'hEF, 8'h00, "R8 od released");

        // R5: set and clear take the pin view
        wr(3'd2, 8'h00);
        pad_chk(8'h2D, 8'hEF, 8'h00, "R5 set bit0");
        wr(3'd3, 8'h05);
        pad_chk(8'h0C, 8'hEF, 8'h00, "R5 clear bit5");

        // R6: analog pins written back as zero, still drivable
        wr(3'd5, 8'h0F);
        wr(3'd2, 8'h07);
        pad_chk(8'hA0, 8'hEF, 8'h00, "R6 rmw analog zero");
        wr(3'd0, 8'h0F);
        pad_chk(8'h0F, 8'hFF, 8'h00, "R6 analog drives");

        // R7: peripheral takeover
        per_sel = 8'h03; per_dout = 8'h01; per_oe = 8'h02;
        #1;
        pad_chk(8'h0D, 8'hFE, 8'h00, "R7 takeover");
        per_sel = 8'h00; per_oe = 8'hFF; per_dout = 8'hF0;
        wr(3'd1, 8'hFF);
        pad_chk(8'h0F, 8'h00, 8'h00, "R7 per_oe ignored");

        // R9: pull-ups
        wr(3'd1, 8'hF0);
        wr(3'd4, 8'h00);
        pad_chk(8'h0F, 8'h0F, 8'hF0, "R9 pullups on inputs");
        rd_chk(3'd4, 8'h00, "R9 puctl read");
        wr(3'd4, 8'h01);
        pad_chk(8'h0F, 8'h0F, 8'h00, "R9 pullups off");

        @(negedge clk); #1;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule